// File: doc/BRIEF.md
# Write Guard with Exact Clock Count

This block sits between the instruction decoder of a three-wire serial memory slave and the path that writes the storage array. It watches each chip-select frame. It ignores the leading clocks on which the data input is still low. Starting at the first clock that carries a one (the start bit), it counts every serial clock edge. When chip select falls, it compares that count with the exact frame length of the write-class instruction the decoder reported. Only an exact match lets the write go ahead. A single extra or missing clock, for example a noise spike, makes an innocent command decode as an erase. Such a frame is turned into a cancel and never reaches the array.

The block also owns the write-enable latch. Enable and disable commands change the latch only when their frame ends. A power-low indication clears the latch at once and poisons the frame in progress. The commit output is a single system-clock pulse that the array write sequencer consumes. The cancel output stays raised until the next frame opens, so that slower logic can observe it.

Top module: `write_guard`

## Requirements
- R1: Serial clock edges in a frame before the first edge with `di`=1 are not counted. The edge that samples the start bit counts as 1.
- R2: Write (`op_class`=1) and write-all (`op_class`=3) commit only if the count at chip-select fall equals 3+ADDR_W+DATA_W (25 with the defaults).
- R3: Erase (`op_class`=2) and erase-all (`op_class`=4) commit only if the count at chip-select fall equals 3+ADDR_W (9 with the defaults).
- R4: A write-class frame that ends with any other count raises `cancel` and does not raise `commit`. The two never assert together.
- R5: Enable (`op_class`=5) sets and disable (`op_class`=6) clears `wr_enabled`, and only at the chip-select fall of a frame that counted at least 3+ADDR_W edges. A shorter frame leaves the latch unchanged.
- R6: `wr_enabled` is 0 after reset. It reads 0 from the first clock edge at which `power_low` is sampled high and stays 0 while that input is high.
- R7: After a power-low event, write-class frames are cancelled until a complete enable frame has ended with `power_low` low. A frame during which `power_low` was seen commits nothing and enables nothing.
- R8: A write-class frame that ends while `wr_enabled` is 0 raises `cancel`, even with a correct count.
- R9: The edge counter saturates at 2^CNT_W-1 (31 with the defaults). A 57-edge write frame is cancelled rather than wrapping to 25.
- R10: `commit` is exactly one clock wide, in the cycle after the one in which `cs_fall` is sampled. `cancel` rises at the same point and stays high until a `cs_rise` is sampled.
- R11: Class 0 (no write effect, e.g. read) and class 7 raise neither `commit` nor `cancel` at frame end.
- R12: A disable frame with one extra noise edge, which the decoder reports as an erase with 10 edges, is cancelled, and `wr_enabled` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_rise | input | 1 | One-cycle pulse: chip select asserted, frame opens |
| cs_fall | input | 1 | One-cycle pulse: chip select released, frame closes |
| sk_rise | input | 1 | One-cycle pulse per serial clock rising edge |
| di | input | 1 | Serial data value sampled with `sk_rise` |
| op_class | input | 3 | Decoded instruction class, valid at `cs_fall` |
| power_low | input | 1 | Supply below safe write level |
| commit | output | 1 | One-cycle pulse: array write may proceed |
| cancel | output | 1 | Last write-class frame was rejected |
| wr_enabled | output | 1 | Write-enable latch state |

## Verification
A wrong internal count shows at the ports no later than the end of that frame. `commit` and `cancel` one cycle after `cs_fall` tell whether the count matched. Frames of 24, 25, 26 and 57 edges, with and without dummy clocks, bracket the exact-length rule and the saturation. A latch in the wrong state shows up either as `wr_enabled` itself or as a correctly sized write that is cancelled or commits when it should not. The bench therefore follows every latch change with a write frame. Power-low poisoning of the frame state becomes visible only in the next write or enable frame, so the bench probes it with exactly such frames.

// File: rtl/write_guard.sv
module write_guard #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_rise,
  input  logic       cs_fall,
  input  logic       sk_rise,
  input  logic       di,
  input  logic [2:0] op_class,
  input  logic       power_low,
  output logic       commit,
  output logic       cancel,
  output logic       wr_enabled
);
  localparam int SHORT_LEN = 3 + ADDR_W;
  localparam int LONG_LEN  = SHORT_LEN + DATA_W;
  localparam int CNT_W     = $clog2(LONG_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LEN);

  localparam logic [2:0] OP_WRITE   = 3'd1;
  localparam logic [2:0] OP_ERASE   = 3'd2;
  localparam logic [2:0] OP_WRALL   = 3'd3;
  localparam logic [2:0] OP_ERALL   = 3'd4;
  localparam logic [2:0] OP_ENABLE  = 3'd5;
  localparam logic [2:0] OP_DISABLE = 3'd6;

  logic             in_frame, started, poison, wen_q, commit_q, cancel_q;
  logic [CNT_W-1:0] cnt;

  wire long_op  = (op_class == OP_WRITE) || (op_class == OP_WRALL);
  wire short_op = (op_class == OP_ERASE) || (op_class == OP_ERALL);
  wire wr_op    = long_op || short_op;
  wire len_ok   = long_op ? (cnt == LONG_C) : (cnt == SHORT_C);
  wire closing  = cs_fall && in_frame;
  wire go       = closing && wr_op && len_ok && wen_q && !poison && !power_low;
  wire reject   = closing && wr_op && !go;
  wire cmd_ok   = closing && !poison && !power_low && (cnt >= SHORT_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      started  <= 1'b0;
      cnt      <= '0;
      poison   <= 1'b0;
      wen_q    <= 1'b0;
      commit_q <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      commit_q <= go;
      if (cs_rise) begin
        in_frame <= 1'b1;
        started  <= 1'b0;
        cnt      <= '0;
        cancel_q <= 1'b0;
        poison   <= power_low;
      end else if (cs_fall) begin
        in_frame <= 1'b0;
        if (reject) cancel_q <= 1'b1;
      end else if (in_frame && sk_rise) begin
        if (started) begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end else if (di) begin
          started <= 1'b1;
          cnt     <= CNT_W'(1);
        end
      end
      if (power_low) poison <= 1'b1;
      if (power_low) wen_q <= 1'b0;
      else if (cmd_ok && op_class == OP_ENABLE) wen_q <= 1'b1;
      else if (cmd_ok && op_class == OP_DISABLE) wen_q <= 1'b0;
    end
  end

  assign commit     = commit_q;
  assign cancel     = cancel_q;
  assign wr_enabled = wen_q;

  assert_commit_cancel_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && cancel));
  assert_plow_clears_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    power_low |=> !wr_enabled);
  assert_commit_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(wen_q));
  assert_cnt_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && in_frame && sk_rise && !cs_rise && !cs_fall) |=> cnt == CNT_MAX);
  assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  assert_commit_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(cs_fall));
  assert_cancel_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !cs_rise) |=> cancel);
endmodule

// File: tb/tb_write_guard.sv
module tb_write_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_rise = 0, cs_fall = 0, sk_rise = 0, di = 0, power_low = 0;
  logic [2:0] op_class = 3'd0;
  logic commit, cancel, wr_enabled;
  int checks = 0, fails = 0;
  bit done = 0;
  logic got_c, got_x, got_w;

  always #2 clk = ~clk;

  write_guard dut (.clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sk_rise(sk_rise), .di(di), .op_class(op_class), .power_low(power_low),
    .commit(commit), .cancel(cancel), .wr_enabled(wr_enabled));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_frame(input logic [2:0] op);
    @(negedge clk); cs_rise = 1; op_class = op;
    @(negedge clk); cs_rise = 0;
  endtask

  task automatic frame(input logic [2:0] op, input int dummies, input int n);
    open_frame(op);
    for (int i = 0; i < dummies; i++) begin
      @(negedge clk); sk_rise = 1; di = 0;
      @(negedge clk); sk_rise = 0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sk_rise = 1; di = (i == 0);
      @(negedge clk); sk_rise = 0; di = 0;
    end
    @(negedge clk); cs_fall = 1;
    @(negedge clk); cs_fall = 0;
    got_c = commit; got_x = cancel; got_w = wr_enabled;
  endtask

  task automatic expect_frame(input logic [2:0] op, input int d, input int n,
                              input bit ec, input bit ex, input string req);
    frame(op, d, n);
    chk(got_c == ec, {req, " commit"}, got_c, ec);
    chk(got_x == ex, {req, " cancel"}, got_x, ex);
  endtask

  task automatic t_reset;
    chk(wr_enabled == 0, "R6 reset latch", wr_enabled, 0);
    chk(commit == 0 && cancel == 0, "R11 reset outputs", {commit, cancel}, 0);
  endtask

  task automatic t_enable;
    frame(3'd5, 0, 5);
    chk(got_w == 0, "R5 short enable ignored", got_w, 0);
    expect_frame(3'd1, 0, 25, 0, 1, "R8 write while disabled");
    frame(3'd5, 2, 9);
    chk(got_w == 1, "R5 enable", got_w, 1);
  endtask

  task automatic t_lengths;
    expect_frame(3'd1, 3, 25, 1, 0, "R1 R2 write with dummies");
    @(negedge clk);
    chk(commit == 0, "R10 commit one wide", commit, 0);
    expect_frame(3'd1, 0, 24, 0, 1, "R2 R4 write short");
    expect_frame(3'd1, 0, 26, 0, 1, "R2 R4 write long");
    expect_frame(3'd3, 0, 25, 1, 0, "R2 write-all");
    expect_frame(3'd2, 1, 9, 1, 0, "R3 erase");
    expect_frame(3'd4, 0, 9, 1, 0, "R3 erase-all");
    expect_frame(3'd4, 0, 8, 0, 1, "R3 R4 erase-all short");
    expect_frame(3'd2, 0, 25, 0, 1, "R3 R4 erase long");
  endtask

  task automatic t_noise;
    expect_frame(3'd2, 0, 10, 0, 1, "R12 noisy disable");
    chk(got_w == 1, "R12 latch kept", got_w, 1);
  endtask

  task automatic t_saturate;
    expect_frame(3'd1, 0, 57, 0, 1, "R9 saturating count");
    expect_frame(3'd1, 0, 25, 1, 0, "R9 normal after");
  endtask

  task automatic t_cancel_hold;
    expect_frame(3'd1, 0, 20, 0, 1, "R10 cancel set");
    repeat (5) @(negedge clk);
    chk(cancel == 1, "R10 cancel held", cancel, 1);
    open_frame(3'd0);
    chk(cancel == 0, "R10 cancel cleared", cancel, 0);
    @(negedge clk); cs_fall = 1;
    @(negedge clk); cs_fall = 0;
  endtask

  task automatic t_neutral;
    expect_frame(3'd0, 0, 25, 0, 0, "R11 class 0");
    expect_frame(3'd7, 0, 9, 0, 0, "R11 class 7");
  endtask

  task automatic t_disable;
    frame(3'd6, 0, 9);
    chk(got_w == 0, "R5 disable", got_w, 0);
    expect_frame(3'd2, 0, 9, 0, 1, "R8 erase while disabled");
  endtask

  task automatic t_power;
    frame(3'd5, 0, 9);
    chk(got_w == 1, "R7 re-enable", got_w, 1);
    @(negedge clk); power_low = 1;
    @(negedge clk);
    chk(wr_enabled == 0, "R6 power low clears", wr_enabled, 0);
    repeat (3) @(negedge clk);
    chk(wr_enabled == 0, "R6 held low", wr_enabled, 0);
    power_low = 0;
    expect_frame(3'd1, 0, 25, 0, 1, "R7 write after power low");
    open_frame(3'd5);
    power_low = 1;
    @(negedge clk); power_low = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); sk_rise = 1; di = (i == 0);
      @(negedge clk); sk_rise = 0; di = 0;
    end
    @(negedge clk); cs_fall = 1;
    @(negedge clk); cs_fall = 0;
    chk(wr_enabled == 0, "R7 poisoned enable", wr_enabled, 0);
    frame(3'd5, 0, 9);
    chk(got_w == 1, "R7 clean enable", got_w, 1);
    expect_frame(3'd1, 0, 25, 1, 0, "R7 write after enable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_lengths();
    t_noise();
    t_saturate();
    t_cancel_hold();
    t_neutral();
    t_disable();
    t_power();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule